// File: doc/BRIEF.md
# Dual-Base Montgomery Exponentiator

This block raises two bases to two exponents at once and multiplies the results together: g0^e0 · g1^e1 mod m. All values stay in the Montgomery domain. The bases, the modulus and the Montgomery image of one (R mod m, with R = 2^N) are supplied by the surrounding logic. The result is returned in the same domain. The modulus must be odd, and every operand must be below it. Each exponent is read as an unsigned integer. The caller chooses how many exponent bits to use at run time.

Before the scan starts, the core prepares a four-entry base table in dual mode: one, g0, g1 and g0·g1. It then walks the bits from the top position down to bit 0. At each position it squares the accumulator once. If the pair of exponent bits at that position is not zero, it multiplies by the table entry that the pair selects. A constant-time option multiplies at every position, using the table's "one" entry when the pair is zero, so the run time no longer depends on the exponent values.

Two further modes use the same sequencer. The single-base mode ignores the second exponent. The multiply mode returns one Montgomery product, g0·g1·R⁻¹ mod m. All multiplications go through one radix-2 Montgomery multiplier that takes N clock cycles per product.

Top module: `dual_base_mont_exp`

## Requirements
- R1: With mode = 2'b00, result = g0·g1·R⁻¹ mod m, with R = 2^N. done pulses exactly N cycles after the start edge, and exp_len is not used.
- R2: With mode = 2'b01, result is the Montgomery image of x0^e0 mod m, where g0 is the Montgomery image of x0. The e1 input has no effect on the result or on the timing.
- R3: With mode = 2'b10 (and mode = 2'b11, which acts the same), result is the Montgomery image of x0^e0 · x1^e1 mod m. This holds for any odd modulus below 2^N and for any pair of exponents, including one that is shorter and padded with zero bits. The result is always below m.
- R4: Without constant time, a run is busy for N·(P + L + K) cycles. P = 1 in dual mode and 0 in single mode. L is the effective length. K is the number of positions below L where the selected exponent bits are not both zero.
- R5: With const_time = 1, a run is busy for N·(P + 2L) cycles, whatever the exponent values. The result is unchanged.
- R6: Only exponent bits 0 to L−1 are used. Bits at or above the effective length have no effect.
- R7: In an exponent mode with an effective length of 0, busy never rises, done pulses in the cycle after the start edge, and result = mont_one.
- R8: An exp_len value above EW is treated as EW.
- R9: done is high for exactly one cycle, busy is low in that cycle, and result holds its value until the next done.
- R10: start is ignored while busy is high. The run in progress keeps its operands and its timing.
- R11: After reset, busy = 0, done = 0 and result = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a run when busy is low |
| mode | input | 2 | 00 multiply, 01 single base, 10/11 dual base |
| const_time | input | 1 | Multiply at every bit position |
| exp_len | input | $clog2(EW+1) | Number of exponent bits to scan |
| g0 | input | N | First base, Montgomery form |
| g1 | input | N | Second base, Montgomery form |
| mont_one | input | N | R mod m |
| modulus | input | N | Odd modulus m |
| e0 | input | EW | First exponent |
| e1 | input | EW | Second exponent |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | N | Latest result, Montgomery form |

## Verification
The bench compares busy, done and result against a behavioural model on every clock. The model computes its expected values with plain wide modular arithmetic. If the multiplier's intermediate sum were one bit too narrow, a modulus close to 2^N would give wrong products. A scan that starts at the wrong end, or indexes the wrong bit, would give wrong powers when the exponents are uneven, padded, or carry bits above the run length. Each of these shows up as a result mismatch. A sequencer that skipped the dummy multiply, or let e1 count in single mode, would shift the cycle at which busy falls. Dropping the zero-length shortcut, ignoring the length clamp, or re-arming on a start while busy would each change the done timing or corrupt the result.

// File: rtl/dual_base_mont_exp.sv
module dual_base_mont_exp #(
  parameter int N  = 64,
  parameter int EW = 16,
  localparam int LW = $clog2(EW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          const_time,
  input  logic [LW-1:0] exp_len,
  input  logic [N-1:0]  g0,
  input  logic [N-1:0]  g1,
  input  logic [N-1:0]  mont_one,
  input  logic [N-1:0]  modulus,
  input  logic [EW-1:0] e0,
  input  logic [EW-1:0] e1,
  output logic          busy,
  output logic          done,
  output logic [N-1:0]  result
);
  localparam int IW = (EW > 1) ? $clog2(EW) : 1;
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_SQR, ST_MUL} st_t;
  st_t st;

  logic [N-1:0]  mq, oneq, g0q, g1q, g01q, acc;
  logic [EW-1:0] e0q, e1q;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic [N+1:0]  t;
  logic          mulq, ctq;

  wire [LW-1:0] len_eff = (exp_len > LW'(EW)) ? LW'(EW) : exp_len;
  wire [LW-1:0] len_m1  = len_eff - 1'b1;
  wire [1:0]    pair    = {e1q[idx], e0q[idx]};
  wire          more    = (pair != 2'b00) || ctq;
  wire          last    = (cnt == CW'(N - 1));
  wire          fin     = (idx == '0);

  logic [N-1:0] tbl;
  always_comb
    case (pair)
      2'b00:   tbl = oneq;
      2'b01:   tbl = g0q;
      2'b10:   tbl = g1q;
      default: tbl = g01q;
    endcase

  wire [N-1:0] a_op = (st == ST_PRE) ? g0q : acc;
  wire [N-1:0] b_op = (st == ST_PRE) ? g1q : (st == ST_SQR) ? acc : tbl;

  wire [N+1:0] s1   = t + (a_op[cnt] ? {2'b00, b_op} : '0);
  wire [N+1:0] s2   = s1[0] ? s1 + {2'b00, mq} : s1;
  wire [N+1:0] tn   = {1'b0, s2[N+1:1]};
  wire [N+1:0] tsub = tn - {2'b00, mq};
  wire [N-1:0] prod = (tn >= {2'b00, mq}) ? tsub[N-1:0] : tn[N-1:0];

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; done <= 1'b0; result <= '0; t <= '0; cnt <= '0;
      mq <= '0; oneq <= '0; g0q <= '0; g1q <= '0; g01q <= '0; acc <= '0;
      e0q <= '0; e1q <= '0; idx <= '0; mulq <= 1'b0; ctq <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          mq   <= modulus;  oneq <= mont_one;
          g0q  <= g0;       g1q  <= g1;
          e0q  <= e0;       e1q  <= (mode == 2'b01) ? '0 : e1;
          acc  <= mont_one; idx  <= len_m1[IW-1:0];
          mulq <= (mode == 2'b00);
          ctq  <= const_time;
          t    <= '0;       cnt  <= '0;
          if (mode == 2'b00)       st <= ST_PRE;
          else if (len_eff == '0) begin
            result <= mont_one;
            done   <= 1'b1;
          end
          else if (mode == 2'b01)  st <= ST_SQR;
          else                     st <= ST_PRE;
        end
      end else begin
        t   <= last ? '0 : tn;
        cnt <= last ? '0 : cnt + 1'b1;
        if (last) begin
          case (st)
            ST_PRE: begin
              if (mulq) begin
                result <= prod; done <= 1'b1; st <= ST_IDLE;
              end else begin
                g01q <= prod; st <= ST_SQR;
              end
            end
            ST_SQR: begin
              acc <= prod;
              if (more)     st <= ST_MUL;
              else if (fin) begin result <= prod; done <= 1'b1; st <= ST_IDLE; end
              else          begin idx <= idx - 1'b1; st <= ST_SQR; end
            end
            default: begin
              acc <= prod;
              if (fin) begin result <= prod; done <= 1'b1; st <= ST_IDLE; end
              else     begin idx <= idx - 1'b1; st <= ST_SQR; end
            end
          endcase
        end
      end
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_result_reduced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < mq));
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(mq) && $stable(e0q) && $stable(e1q)));
  assert_partial_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (t < ({2'b00, mq} << 1)));
  assert_ct_dummy_mul_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SQR && last && ctq) |=> (st == ST_MUL));
  assert_single_e1_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mode == 2'b01) |=> (e1q == '0));
endmodule

// File: tb/test_dual_base_mont_exp.sv
module test_dual_base_mont_exp;
  localparam int N  = 64;
  localparam int EW = 16;
  localparam int LW = $clog2(EW + 1);
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, const_time = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [LW-1:0] exp_len = '0;
  logic [N-1:0] g0 = '0, g1 = '0, mont_one = '0, modulus = 64'h1;
  logic [EW-1:0] e0 = '0, e1 = '0;
  logic busy, done;
  logic [N-1:0] result;

  dual_base_mont_exp #(.N(N), .EW(EW)) i_dual_base_mont_exp (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .const_time(const_time),
    .exp_len(exp_len), .g0(g0), .g1(g1), .mont_one(mont_one), .modulus(modulus),
    .e0(e0), .e1(e1), .busy(busy), .done(done), .result(result));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit checking = 0;

  function automatic logic [N-1:0] mulmod(input logic [N-1:0] a, b, m);
    logic [2*N-1:0] p;
    p = {{N{1'b0}}, a} * {{N{1'b0}}, b};
    p = p % {{N{1'b0}}, m};
    return p[N-1:0];
  endfunction

  function automatic logic [N-1:0] tomont(input logic [N-1:0] x, m);
    logic [2*N-1:0] p;
    p = {x, {N{1'b0}}} % {{N{1'b0}}, m};
    return p[N-1:0];
  endfunction

  function automatic logic [N-1:0] powmod(input logic [N-1:0] g, input logic [EW-1:0] e,
                                          input int len, input logic [N-1:0] m);
    logic [N-1:0] r;
    r = 1;
    for (int i = len - 1; i >= 0; i--) begin
      r = mulmod(r, r, m);
      if (e[i]) r = mulmod(r, g, m);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp_v);
    end
  endtask

  // plain-domain stimulus seen by the model
  logic [N-1:0] p_m, p_g0, p_g1;
  logic [EW-1:0] p_e0, p_e1;
  int p_len; logic [1:0] p_mode; bit p_ct; string p_tag;

  // reference model
  int rem = 0;
  bit mdone = 0;
  logic [N-1:0] mres, pend, lres = '0;
  string mtag = "R1", ttag = "R4";

  always @(posedge clk) begin
    if (!rst_n) begin
      rem = 0; mdone = 0;
    end else begin
      mdone = 0;
      if (rem > 0) begin
        if (rem == 1) begin mdone = 1; mres = pend; end
        rem = rem - 1;
      end else if (start) begin
        int L, nz;
        logic [EW-1:0] m0, m1;
        mtag = p_tag;
        ttag = p_ct ? "R5" : "R4";
        L = (p_len > EW) ? EW : p_len;
        m0 = p_e0; m1 = (p_mode == 2'b01) ? '0 : p_e1;
        if (p_mode == 2'b00) begin
          pend = tomont(mulmod(p_g0, p_g1, p_m), p_m);
          rem = N;
        end else begin
          pend = tomont(mulmod(powmod(p_g0, m0, L, p_m), powmod(p_g1, m1, L, p_m), p_m), p_m);
          nz = 0;
          for (int i = 0; i < L; i++) nz += (m0[i] | m1[i]) ? 1 : 0;
          if (L == 0) begin mdone = 1; mres = pend; end
          else rem = N * (((p_mode == 2'b01) ? 0 : 1) + L + (p_ct ? L : nz));
        end
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      chk(busy == (rem > 0), ttag, N'(busy), N'(rem > 0));
      chk(done == mdone, "R9", N'(done), N'(mdone));
      if (mdone) begin
        chk(result == mres, mtag, result, mres);
        lres = mres;
      end else chk(result == lres, "R9", result, lres);
    end
  end

  task automatic drive(input logic [N-1:0] m, x0, x1, input logic [EW-1:0] a0, a1,
                       input int len, input logic [1:0] md, input bit ct);
    modulus = m; g0 = tomont(x0 % m, m); g1 = tomont(x1 % m, m);
    mont_one = tomont(1, m); e0 = a0; e1 = a1; exp_len = LW'(len);
    mode = md; const_time = ct;
  endtask

  task automatic run(input logic [N-1:0] m, x0, x1, input logic [EW-1:0] a0, a1,
                     input int len, input logic [1:0] md, input bit ct, input string tg);
    @(negedge clk);
    p_m = m; p_g0 = x0 % m; p_g1 = x1 % m; p_e0 = a0; p_e1 = a1;
    p_len = len; p_mode = md; p_ct = ct; p_tag = tg;
    drive(m, x0, x1, a0, a1, len, md, ct);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R4: watchdog expired got %0d expected below %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [N-1:0] M1 = 64'hF123_4567_89AB_CDEF;
  localparam logic [N-1:0] M2 = 64'hFFFF_FFFF_FFFF_FFC5;
  localparam logic [N-1:0] M3 = 64'h0000_0000_0000_00C5;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R11", N'(busy), '0);
    chk(done == 1'b0, "R11", N'(done), '0);
    chk(result == '0, "R11", result, '0);
    checking = 1;

    run(M1, 64'h1234_5678_9ABC_DEF1, 64'h0FED_CBA9_8765_4321, 16'h0, 16'h0, 0, 2'b00, 0, "R1");
    run(M2, 64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FE11, 16'h0, 16'h0, 9, 2'b00, 0, "R1");
    run(M1, 64'h0000_0000_DEAD_BEEF, 64'h5555, 16'hB35A, 16'hFFFF, 16, 2'b01, 0, "R2");
    run(M1, 64'h0000_0000_DEAD_BEEF, 64'h7777, 16'hB35A, 16'hC003, 16, 2'b10, 0, "R3");
    run(M2, 64'hFFFF_FFFF_0000_1234, 64'hABCD_EF01_2345_6789, 16'hFFFF, 16'h0013, 16, 2'b11, 0, "R3");
    run(M3, 64'h17, 64'h5B, 16'h0000, 16'h8421, 16, 2'b10, 0, "R3");
    run(M1, 64'h0000_0003_1415_9265, 64'h2718_2818, 16'h8001, 16'h0100, 16, 2'b10, 1, "R5");
    run(M2, 64'h0000_0000_0000_0002, 64'h9, 16'h0020, 16'hFFFF, 12, 2'b01, 1, "R5");
    run(M1, 64'h0000_0000_0000_1357, 64'h2468, 16'hFFE5, 16'hAB0A, 5, 2'b10, 0, "R6");
    run(M1, 64'h0000_0000_0000_0099, 64'h77, 16'hFFFF, 16'hFFFF, 0, 2'b10, 0, "R7");
    run(M3, 64'h3, 64'h5, 16'h0001, 16'h0, 0, 2'b01, 0, "R7");
    run(M1, 64'h0000_0000_0BAD_F00D, 64'h4321, 16'h9C3E, 16'h1111, 31, 2'b10, 0, "R8");

    // R10: a second start while busy must be ignored
    @(negedge clk);
    p_m = M1; p_g0 = 64'h0000_0000_CAFE_0001; p_g1 = 64'h0000_0000_0000_0101;
    p_e0 = 16'h00F3; p_e1 = 16'h0071; p_len = 8; p_mode = 2'b10; p_ct = 0; p_tag = "R10";
    drive(p_m, p_g0, p_g1, p_e0, p_e1, p_len, p_mode, p_ct);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    drive(M3, 64'h11, 64'h22, 16'hFFFF, 16'hFFFF, 3, 2'b00, 1);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule